// File: doc/BRIEF.md
# Slow Control Channel Rate Filter

This block watches the rate pointer that the far end of a radio fronthaul link places in a fixed control byte. It takes the pointer once per hyperframe and does not act on it until it has proven stable. A changed pointer is adopted as the receive rate of the slow control channel only after the same new value has been seen in four hyperframes in a row. Any other value restarts the run. Receiving the rate already in force cancels any pending run. While the link has not reached frame synchronisation, nothing is counted and the adopted rate stays as it is.

The transmit rate comes from a separate path. A field of a software-written configuration word sets it, and the persistence filter never touches it. Both rate codes are decoded to a bit rate in kbit/s, and that decode depends on the current line rate. The line rate is given as a multiple of 614.4 Mbit/s. The adopted receive code is also placed in a field of a status word. A one-cycle pulse marks each adoption.

Top module: `ctlrate_filter`

## Requirements
- R1: After reset the accepted receive code is 0, the change pulse is low and the status word is all zeros.
- R2: The pointer is bits [2:0] of `ctl_byte`, sampled only in a cycle where `hf_strobe` is high. Bits [7:3] and cycles without the strobe have no effect.
- R3: A pointer value different from the accepted code becomes the accepted code when it arrives in four consecutive synchronised hyperframes. The new code is visible on `rx_rate` in the cycle after the fourth strobe.
- R4: A pointer that differs from both the accepted code and the current candidate makes it the new candidate with a run length of one.
- R5: A pointer equal to the accepted code discards any pending candidate, so a following new value starts again from one.
- R6: While `link_synced` is low, the run length is held at zero and the accepted code is kept. Strobes in that state are ignored.
- R7: `rate_changed` is high for exactly the one cycle in which `rx_rate` takes its new value, and is low at all other times.
- R8: `status_word` carries the accepted code in bits [2:0]. All its other bits are zero.
- R9: The transmit code is bits [6:4] of `cfg_word` and is reported at once on `tx_rate`. It has no effect on the receive path.
- R10: Rate decode maps a code to a multiplier m: code 0 gives m=0 (channel off), codes 1 to 5 give m=code, code 6 gives m=8, and code 7 gives m=`line_mult`. The rate is 480*m kbit/s when m is nonzero and m <= `line_mult`, and 0 otherwise.
- R11: As a result, code 6 yields 3840 kbit/s only when `line_mult` >= 8 (4915.2 Mbit/s), and code 7 yields 480*`line_mult` (4800 kbit/s at `line_mult` = 10). The same decode applies to `rx_kbps` and `tx_kbps`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hf_strobe | input | 1 | One-cycle pulse per received hyperframe |
| ctl_byte | input | 8 | Received control byte carrying the rate pointer |
| link_synced | input | 1 | Link has frame synchronisation |
| cfg_word | input | 8 | Software configuration word holding the transmit code |
| line_mult | input | 4 | Line rate as a multiple of 614.4 Mbit/s |
| rx_rate | output | 3 | Accepted receive rate code |
| status_word | output | 8 | Status word with the receive rate field |
| rx_kbps | output | 16 | Decoded receive bit rate in kbit/s |
| tx_rate | output | 3 | Transmit rate code |
| tx_kbps | output | 16 | Decoded transmit bit rate in kbit/s |
| rate_changed | output | 1 | One-cycle pulse on adoption of a new receive code |

## Verification
The checker holds on every cycle several properties. The accepted code only moves together with the change pulse, and the pulse never lasts two cycles. Nothing is adopted without a strobe or while the link is unsynchronised. The transmit decode of codes 6 and 7 follows the line rate. Only the bench scenarios can show that adoption needs exactly four matching hyperframes. The same holds for the restart rule on a differing value and for the cancelling effect of the accepted value. Both rely on a history that a reference model in the bench tracks across random pointer runs and dropped synchronisation.

// File: rtl/ctlrate_pkg.sv
package ctlrate_pkg;
   localparam int PTR_W    = 3;
   localparam int CODE_OFF = 0;
   localparam int CODE_HI  = 6;
   localparam int CODE_MAX = 7;
   typedef logic [PTR_W-1:0] rate_code_t;
endpackage

// File: rtl/ctlrate_persist.sv
module ctlrate_persist
   import ctlrate_pkg::*;
#(
   parameter int PERSIST  = 4,
   parameter int RST_CODE = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hf_strobe,
   input  logic       link_synced,
   input  rate_code_t ptr_in,
   output rate_code_t acc_code,
   output logic       acc_pulse
);
   localparam int CNT_W = $clog2(PERSIST + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST - 1);

   if (PERSIST < 2) begin : g_bad_persist
      $error("ctlrate_persist: PERSIST must be at least 2");
   end
   if (RST_CODE > CODE_MAX) begin : g_bad_rst
      $error("ctlrate_persist: RST_CODE out of range");
   end

   rate_code_t       cand_q;
   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_code  <= rate_code_t'(RST_CODE);
         cand_q    <= '0;
         run_q     <= '0;
         acc_pulse <= 1'b0;
      end else begin
         acc_pulse <= 1'b0;
         if (!link_synced) begin
            run_q <= '0;
         end else if (hf_strobe) begin
            if (ptr_in == acc_code) begin
               run_q <= '0;
            end else if (run_q != '0 && ptr_in == cand_q) begin
               if (run_q == LAST) begin
                  acc_code  <= ptr_in;
                  run_q     <= '0;
                  acc_pulse <= 1'b1;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               cand_q <= ptr_in;
               run_q  <= CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/ctlrate_decode.sv
module ctlrate_decode
   import ctlrate_pkg::*;
#(
   parameter int LR_W    = 4,
   parameter int KBPS_W  = 16,
   parameter int STEP    = 480,
   parameter int HI_MULT = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rate_code_t        code,
   input  logic [LR_W-1:0]   line_mult,
   output logic [KBPS_W-1:0] kbps
);
   localparam int MAX_KBPS = STEP * ((1 << LR_W) - 1);

   if (MAX_KBPS >= (1 << KBPS_W)) begin : g_bad_width
      $error("ctlrate_decode: KBPS_W too small for STEP and LR_W");
   end
   if (HI_MULT >= (1 << LR_W)) begin : g_bad_hi
      $error("ctlrate_decode: HI_MULT does not fit LR_W");
   end

   logic [LR_W-1:0]   mult;
   logic [KBPS_W-1:0] rate_c;

   always_comb begin
      case (code)
         rate_code_t'(CODE_OFF): mult = '0;
         rate_code_t'(CODE_HI):  mult = LR_W'(HI_MULT);
         rate_code_t'(CODE_MAX): mult = line_mult;
         default:                mult = LR_W'(code);
      endcase
      if (mult != '0 && mult <= line_mult) begin
         rate_c = KBPS_W'(mult) * KBPS_W'(STEP);
      end else begin
         rate_c = '0;
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) kbps <= '0;
         else        kbps <= rate_c;
      end
   end else begin : g_comb
      assign kbps = rate_c;
   end
endmodule

// File: rtl/ctlrate_filter.sv
module ctlrate_filter
   import ctlrate_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int CFG_W    = 8,
   parameter int TX_LSB   = 4,
   parameter int STAT_W   = 8,
   parameter int RX_LSB   = 0,
   parameter int LR_W     = 4,
   parameter int KBPS_W   = 16,
   parameter int STEP     = 480,
   parameter int HI_MULT  = 8,
   parameter int PERSIST  = 4,
   parameter int RST_CODE = 0,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hf_strobe,
   input  logic [BYTE_W-1:0] ctl_byte,
   input  logic              link_synced,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic [LR_W-1:0]   line_mult,
   output logic [PTR_W-1:0]  rx_rate,
   output logic [STAT_W-1:0] status_word,
   output logic [KBPS_W-1:0] rx_kbps,
   output logic [PTR_W-1:0]  tx_rate,
   output logic [KBPS_W-1:0] tx_kbps,
   output logic              rate_changed
);
   if (BYTE_W < PTR_W) begin : g_bad_byte
      $error("ctlrate_filter: BYTE_W too narrow");
   end
   if (CFG_W < TX_LSB + PTR_W) begin : g_bad_cfg
      $error("ctlrate_filter: transmit field outside CFG_W");
   end
   if (STAT_W < RX_LSB + PTR_W) begin : g_bad_stat
      $error("ctlrate_filter: receive field outside STAT_W");
   end

   rate_code_t ptr;
   rate_code_t acc;

   assign ptr     = ctl_byte[PTR_W-1:0];
   assign rx_rate = acc;
   assign tx_rate = cfg_word[TX_LSB +: PTR_W];

   always_comb begin
      status_word = '0;
      status_word[RX_LSB +: PTR_W] = acc;
   end

   ctlrate_persist #(.PERSIST(PERSIST), .RST_CODE(RST_CODE)) i_persist (
      .clk        (clk),
      .rst_n      (rst_n),
      .hf_strobe  (hf_strobe),
      .link_synced(link_synced),
      .ptr_in     (ptr),
      .acc_code   (acc),
      .acc_pulse  (rate_changed)
   );

   ctlrate_decode #(.LR_W(LR_W), .KBPS_W(KBPS_W), .STEP(STEP),
                    .HI_MULT(HI_MULT), .OUT_REG(OUT_REG)) i_rx_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (acc),
      .line_mult(line_mult),
      .kbps     (rx_kbps)
   );

   ctlrate_decode #(.LR_W(LR_W), .KBPS_W(KBPS_W), .STEP(STEP),
                    .HI_MULT(HI_MULT), .OUT_REG(OUT_REG)) i_tx_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (tx_rate),
      .line_mult(line_mult),
      .kbps     (tx_kbps)
   );
endmodule

// File: rtl/ctlrate_filter_chk.sv
module ctlrate_filter_chk #(
   parameter int LR_W    = 4,
   parameter int KBPS_W  = 16,
   parameter int STEP    = 480,
   parameter int HI_MULT = 8,
   parameter bit OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hf_strobe,
   input logic              link_synced,
   input logic [2:0]        rx_rate,
   input logic              rate_changed,
   input logic [2:0]        tx_rate,
   input logic [LR_W-1:0]   line_mult,
   input logic [KBPS_W-1:0] tx_kbps
);
   // R7
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rate_changed |=> !rate_changed);

   // R7
   move_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_rate) |-> rate_changed);

   // R2
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hf_strobe |=> $stable(rx_rate));

   // R6
   unsynced_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !link_synced |=> (!rate_changed && $stable(rx_rate)));

   if (!OUT_REG) begin : g_dec_chk
      // R11
      hi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_rate == 3'd6) |-> (tx_kbps == ((line_mult >= LR_W'(HI_MULT))
                                ? KBPS_W'(HI_MULT * STEP) : '0)));

      // R11
      top_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_rate == 3'd7) |-> (tx_kbps == KBPS_W'(line_mult) * KBPS_W'(STEP)));
   end
endmodule

bind ctlrate_filter ctlrate_filter_chk #(
   .LR_W(LR_W), .KBPS_W(KBPS_W), .STEP(STEP), .HI_MULT(HI_MULT), .OUT_REG(OUT_REG)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hf_strobe   (hf_strobe),
   .link_synced (link_synced),
   .rx_rate     (rx_rate),
   .rate_changed(rate_changed),
   .tx_rate     (tx_rate),
   .line_mult   (line_mult),
   .tx_kbps     (tx_kbps)
);

// File: tb/test_ctlrate_filter.sv
module test_ctlrate_filter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        hf_strobe;
   logic [7:0]  ctl_byte;
   logic        link_synced;
   logic [7:0]  cfg_word;
   logic [3:0]  line_mult;
   logic [2:0]  rx_rate;
   logic [7:0]  status_word;
   logic [15:0] rx_kbps;
   logic [2:0]  tx_rate;
   logic [15:0] tx_kbps;
   logic        rate_changed;

   int checks = 0;
   int errors = 0;

   logic [2:0] m_acc;
   logic [2:0] m_cand;
   int         m_run;

   always #2.5 clk = ~clk;

   ctlrate_filter i_ctlrate_filter (
      .clk(clk), .rst_n(rst_n), .hf_strobe(hf_strobe), .ctl_byte(ctl_byte),
      .link_synced(link_synced), .cfg_word(cfg_word), .line_mult(line_mult),
      .rx_rate(rx_rate), .status_word(status_word), .rx_kbps(rx_kbps),
      .tx_rate(tx_rate), .tx_kbps(tx_kbps), .rate_changed(rate_changed)
   );

   function automatic int exp_kbps(input logic [2:0] code, input logic [3:0] lr);
      int m;
      case (code)
         3'd0: m = 0;
         3'd6: m = 8;
         3'd7: m = int'(lr);
         default: m = int'(code);
      endcase
      if (m != 0 && m <= int'(lr)) return 480 * m;
      return 0;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_outputs(input bit exp_pulse);
      check("R3 rx_rate", int'(rx_rate), int'(m_acc));
      check("R7 rate_changed", int'(rate_changed), int'(exp_pulse));
      check("R8 status_word", int'(status_word), int'(m_acc));
      check("R9 tx_rate", int'(tx_rate), int'(cfg_word[6:4]));
      check("R10 rx_kbps", int'(rx_kbps), exp_kbps(m_acc, line_mult));
      check("R11 tx_kbps", int'(tx_kbps), exp_kbps(cfg_word[6:4], line_mult));
   endtask

   task automatic hyper(input logic [7:0] b, input bit sync);
      logic [2:0] p;
      bit pulse;
      @(negedge clk);
      ctl_byte = b; link_synced = sync; hf_strobe = 1'b1;
      @(negedge clk);
      hf_strobe = 1'b0;
      ctl_byte = ~b;
      p = b[2:0];
      pulse = 1'b0;
      if (!sync) m_run = 0;
      else if (p == m_acc) m_run = 0;
      else if (m_run != 0 && p == m_cand) begin
         if (m_run == 3) begin m_acc = p; m_run = 0; pulse = 1'b1; end
         else m_run++;
      end else begin
         m_cand = p; m_run = 1;
      end
      check_outputs(pulse);
      @(negedge clk);
      check("R7 pulse ends", int'(rate_changed), 0);
      check("R2 no strobe", int'(rx_rate), int'(m_acc));
   endtask

   task automatic idle(input int n, input bit sync);
      link_synced = sync;
      if (!sync) m_run = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ctl_byte = 8'($urandom);
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; hf_strobe = 1'b0; ctl_byte = '0; link_synced = 1'b0;
      cfg_word = 8'h00; line_mult = 4'd10;
      m_acc = 3'd0; m_cand = 3'd0; m_run = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rx_rate", int'(rx_rate), 0);
      check("R1 rate_changed", int'(rate_changed), 0);
      check("R1 status_word", int'(status_word), 0);

      // R4 restart: 5,5,5 then 1 then 5 x4 ; R3 adoption on the fourth
      link_synced = 1'b1;
      repeat (3) hyper(8'h05, 1'b1);
      hyper(8'h01, 1'b1);
      check("R4 not adopted", int'(rx_rate), 0);
      repeat (4) hyper(8'h05, 1'b1);
      check("R3 adopted 5", int'(rx_rate), 5);

      // R5 accepted value cancels candidate; R2 upper bits ignored
      hyper(8'hFA, 1'b1);
      hyper(8'h02, 1'b1);
      hyper(8'h85, 1'b1);
      repeat (3) hyper(8'h32, 1'b1);
      check("R5 still 5", int'(rx_rate), 5);
      hyper(8'hC2, 1'b1);
      check("R5 R2 adopted 2", int'(rx_rate), 2);

      // R6 loss of sync clears the run and ignores strobes
      repeat (3) hyper(8'h06, 1'b1);
      idle(2, 1'b0);
      repeat (5) hyper(8'h06, 1'b0);
      check("R6 retained", int'(rx_rate), 2);
      idle(1, 1'b1);
      hyper(8'h06, 1'b1);
      check("R6 run restarted", int'(rx_rate), 2);
      repeat (3) hyper(8'h06, 1'b1);
      check("R6 adopted 6", int'(rx_rate), 6);

      // R10 R11 decode corners
      line_mult = 4'd7;  cfg_word = 8'h60; hyper(8'h06, 1'b1);
      check("R11 code6 low line", int'(tx_kbps), 0);
      line_mult = 4'd8;  hyper(8'h06, 1'b1);
      check("R11 code6 3840", int'(tx_kbps), 3840);
      line_mult = 4'd10; cfg_word = 8'h70; hyper(8'h06, 1'b1);
      check("R11 code7 4800", int'(tx_kbps), 4800);
      line_mult = 4'd2;  cfg_word = 8'h30; hyper(8'h06, 1'b1);
      check("R10 code3 too fast", int'(tx_kbps), 0);
      cfg_word = 8'h8F; hyper(8'h06, 1'b1);
      check("R10 code0 off", int'(tx_kbps), 0);

      // random runs
      for (int k = 0; k < 400; k++) begin
         logic [7:0] b;
         bit s;
         b = 8'($urandom);
         case ($urandom_range(0, 3))
            0: b[2:0] = m_acc;
            1, 2: b[2:0] = m_cand;
            default: ;
         endcase
         s = ($urandom_range(0, 9) != 0);
         cfg_word  = 8'($urandom);
         line_mult = 4'($urandom);
         hyper(b, s);
         idle($urandom_range(0, 2), s);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule